// File: doc/BRIEF.md
# CAS-Before-RAS Refresh Scheduler

This block keeps a 512-row dynamic RAM refreshed without ever driving a row address. It does this with CAS-before-RAS cycles, where the memory's internal row counter picks the row. The block owns the RAS and CAS strobes whenever it refreshes. An access sequencer shares those strobes with it and runs the normal read and write cycles.

After reset the block first sits out a power-up pause, with both strobes high. It then runs a back-to-back burst of refresh cycles on its own and raises `init_done_o`. Until that output is high, the access sequencer must stay off the bus.

In normal operation an interval timer adds one owed refresh every `INTERVAL_CYC` clocks. Owed refreshes are kept in a saturating count. While that count is non-zero the block raises a request. The sequencer closes its open page and answers with a grant. The block then drives one refresh cycle and pulses a done signal as it hands the bus back. When the owed count reaches a threshold, the block raises an urgent flag, which the sequencer uses to give refresh priority.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While `rst_ni` is low, `ras_n_o` and `cas_n_o` are high, and `ref_req_o`, `ref_done_o`, `ref_urgent_o` and `init_done_o` are low.
- R2: For the first `PAUSE_CYC` clock edges after reset release, both strobes stay high. `init_done_o` first reads high after exactly `PAUSE_CYC + INIT_BURST*(CSR_CYC+RAS_CYC+RP_CYC+1)` edges.
- R3: Exactly `INIT_BURST` refresh cycles occur before `init_done_o` rises. `ref_req_o` is never high while `init_done_o` is low, and `init_done_o` never falls again until reset.
- R4: Every falling edge of `ras_n_o` finds `cas_n_o` already low, and `cas_n_o` has been low for exactly `CSR_CYC` cycles before that edge.
- R5: `cas_n_o` stays low for exactly `CHR_CYC` cycles counted from the first cycle with `ras_n_o` low.
- R6: `ras_n_o` stays low for exactly `RAS_CYC` cycles. `cas_n_o` falls only after `ras_n_o` has been high for at least `RP_CYC` cycles.
- R7: `we_n_o` (the write strobe) is high at all times.
- R8: After `init_done_o` rises, one refresh becomes owed every `INTERVAL_CYC` edges. The first `ref_req_o` appears exactly `INTERVAL_CYC` edges after the edge that raised `init_done_o`.
- R9: A grant counts only while `ref_req_o` is high. The refresh cycle starts at that edge. `ref_done_o` is high for exactly one cycle, the `CSR_CYC+RAS_CYC+RP_CYC`-th cycle after the grant edge. No strobe activity happens without an owed refresh.
- R10: If an interval tick and an accepted grant fall on the same edge, both are counted: the owed count stays unchanged.
- R11: The owed count saturates at `MAX_PEND`. Ticks beyond that are lost, so a later drain with the grant held high yields exactly `MAX_PEND` refresh cycles.
- R12: `ref_urgent_o` is high exactly when the owed count is at least `URGENT_LVL`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_gnt_i | input | 1 | Bus granted by the access sequencer (page closed) |
| ref_req_o | output | 1 | At least one refresh is owed and the bus is wanted |
| ref_urgent_o | output | 1 | Owed count has reached the urgency threshold |
| ref_done_o | output | 1 | One-cycle pulse as the refresh cycle ends and the bus is released |
| init_done_o | output | 1 | Pause and initial burst finished; accesses allowed |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write strobe, held inactive |

## Verification
An interval tick and an accepted grant can land on the same clock edge. The owed counter then sees an increment and a decrement together. The bench times a grant to coincide with the tick that owes a second refresh. It judges the result by watching `ref_req_o` reassert right after the first refresh completes, and drop only after a second grant. A counter that dropped either event would leave the request low too early, or keep it high too long.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  typedef enum logic [1:0] {
    ST_PAUSE = 2'd0,
    ST_INIT  = 2'd1,
    ST_IDLE  = 2'd2,
    ST_REF   = 2'd3
  } cbr_state_e;
endpackage

// File: rtl/cbr_tick_gen.sv
module cbr_tick_gen #(
  parameter int PERIOD = 1950
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!en_i)    cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (PERIOD > 1) begin : g_spacing
      assert_tick_spacing_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/cbr_pend_cnt.sv
module cbr_pend_cnt #(
  parameter int MAX_PEND   = 8,
  parameter int URGENT_LVL = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output logic any_o,
  output logic urgent_o
);
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam logic [PW-1:0] TOP = PW'(MAX_PEND);
  localparam logic [PW-1:0] URG = PW'(URGENT_LVL);

  logic [PW-1:0] pend_q;

  assign any_o    = (pend_q != '0);
  assign urgent_o = (pend_q >= URG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else begin
      case ({inc_i, dec_i})
        2'b10:   if (pend_q != TOP) pend_q <= pend_q + 1'b1;
        2'b01:   if (pend_q != '0)  pend_q <= pend_q - 1'b1;
        default: pend_q <= pend_q; // tick and grant together cancel
      endcase
    end
  end

  assert_dec_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (pend_q != '0));
  assert_sat_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q == TOP && !dec_i) |=> (pend_q == TOP));
  assert_both_keep_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && dec_i) |=> $stable(pend_q));
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq #(
  parameter int CSR_CYC = 2,
  parameter int RAS_CYC = 9,
  parameter int CHR_CYC = 2,
  parameter int RP_CYC  = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic active_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int TOTAL = CSR_CYC + RAS_CYC + RP_CYC;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] RAS_ON  = CW'(CSR_CYC);
  localparam logic [CW-1:0] RAS_OFF = CW'(CSR_CYC + RAS_CYC);
  localparam logic [CW-1:0] CAS_OFF = CW'(CSR_CYC + CHR_CYC);
  localparam logic [CW-1:0] LAST    = CW'(TOTAL - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;

  assign active_o = active_q;
  assign done_o   = active_q && (cnt_q == LAST);
  assign ras_n_o  = !(active_q && cnt_q >= RAS_ON && cnt_q < RAS_OFF);
  assign cas_n_o  = !(active_q && cnt_q < CAS_OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (done_o) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assert_cbr_order_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> !cas_n_o);
  assert_start_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_pkg::*;
#(
  parameter int PAUSE_CYC    = 25000,
  parameter int INTERVAL_CYC = 1950,
  parameter int INIT_BURST   = 8,
  parameter int MAX_PEND     = 8,
  parameter int URGENT_LVL   = 6,
  parameter int CSR_CYC      = 2,
  parameter int RAS_CYC      = 9,
  parameter int CHR_CYC      = 2,
  parameter int RP_CYC       = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_gnt_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic ref_done_o,
  output logic init_done_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic we_n_o
);
  localparam int BW = (INIT_BURST > 1) ? $clog2(INIT_BURST) : 1;
  localparam logic [BW-1:0] BURST_LAST = BW'(INIT_BURST - 1);

  cbr_state_e    state_q, state_d;
  logic [BW-1:0] burst_q;
  logic          pause_tick, int_tick;
  logic          pend_any, accept;
  logic          seq_start, seq_active, seq_done;

  assign init_done_o = (state_q == ST_IDLE) || (state_q == ST_REF);
  assign ref_req_o   = (state_q == ST_IDLE) && pend_any;
  assign accept      = ref_req_o && ref_gnt_i;
  assign seq_start   = accept || ((state_q == ST_INIT) && !seq_active);
  assign ref_done_o  = (state_q == ST_REF) && seq_done;
  assign we_n_o      = 1'b1;

  cbr_tick_gen #(.PERIOD(PAUSE_CYC)) u_pause (
    .clk_i, .rst_ni, .en_i(state_q == ST_PAUSE), .tick_o(pause_tick)
  );

  cbr_tick_gen #(.PERIOD(INTERVAL_CYC)) u_interval (
    .clk_i, .rst_ni, .en_i(init_done_o), .tick_o(int_tick)
  );

  cbr_pend_cnt #(.MAX_PEND(MAX_PEND), .URGENT_LVL(URGENT_LVL)) u_pend (
    .clk_i, .rst_ni, .inc_i(int_tick), .dec_i(accept),
    .any_o(pend_any), .urgent_o(ref_urgent_o)
  );

  cbr_strobe_seq #(
    .CSR_CYC(CSR_CYC), .RAS_CYC(RAS_CYC), .CHR_CYC(CHR_CYC), .RP_CYC(RP_CYC)
  ) u_seq (
    .clk_i, .rst_ni, .start_i(seq_start), .active_o(seq_active),
    .done_o(seq_done), .ras_n_o, .cas_n_o
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_PAUSE: if (pause_tick) state_d = ST_INIT;
      ST_INIT:  if (seq_done && burst_q == BURST_LAST) state_d = ST_IDLE;
      ST_IDLE:  if (accept) state_d = ST_REF;
      ST_REF:   if (seq_done) state_d = ST_IDLE;
      default:  state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PAUSE;
      burst_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_INIT && seq_done) burst_q <= burst_q + 1'b1;
    end
  end

  assert_pause_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSE) |-> (ras_n_o && cas_n_o));
  assert_init_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done_o |=> init_done_o);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_done_o |=> !ref_done_o);
  assert_req_waits_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_gnt_i) |=> ref_req_o);
endmodule

// File: tb/cbr_refresh_sched_test.sv
`timescale 1ns/1ps
module cbr_refresh_sched_test;
  localparam int PAUSE = 20;
  localparam int IV    = 60;
  localparam int BURST = 8;
  localparam int MAXP  = 4;
  localparam int URG   = 3;
  localparam int CSR   = 1;
  localparam int RASC  = 3;
  localparam int CHR   = 1;
  localparam int RP    = 2;
  localparam int TOT   = CSR + RASC + RP;
  localparam int NINIT = PAUSE + BURST * (TOT + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ref_gnt_i = 1'b0;
  logic ref_req_o, ref_urgent_o, ref_done_o, init_done_o;
  logic ras_n_o, cas_n_o, we_n_o;

  int total = 0, bad = 0, e = 0;
  int cbr_cnt = 0;
  int cas_run = 0, ras_run = 0, ras_hi_run = 1000, hold_run = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  bit we_ok = 1'b1, req_early = 1'b0, finished = 1'b0;

  always #4 clk_i = ~clk_i;

  cbr_refresh_sched #(
    .PAUSE_CYC(PAUSE), .INTERVAL_CYC(IV), .INIT_BURST(BURST), .MAX_PEND(MAXP),
    .URGENT_LVL(URG), .CSR_CYC(CSR), .RAS_CYC(RASC), .CHR_CYC(CHR), .RP_CYC(RP)
  ) uut (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    e++;
  endtask

  task automatic step_to(input int target);
    while (e < target) step();
  endtask

  // strobe protocol monitor
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      if (!ras_n_o && prev_ras) begin
        chk(!cas_n_o, "R4 cas low at ras fall", cas_n_o, 0);
        chk(cas_run == CSR, "R4 cas lead cycles", cas_run, CSR);
        cbr_cnt++;
      end
      if (ras_n_o && !prev_ras) chk(ras_run == RASC, "R6 ras low width", ras_run, RASC);
      if (cas_n_o && !prev_cas) chk(hold_run == CHR, "R5 cas hold", hold_run, CHR);
      if (!cas_n_o && prev_cas) chk(ras_hi_run >= RP, "R6 precharge", ras_hi_run, RP);
      if (!we_n_o) we_ok = 1'b0;
      if (ref_req_o && !init_done_o) req_early = 1'b1;
      cas_run    = cas_n_o ? 0 : cas_run + 1;
      ras_run    = ras_n_o ? 0 : ras_run + 1;
      ras_hi_run = ras_n_o ? ras_hi_run + 1 : 0;
      hold_run   = cas_n_o ? 0 : (ras_n_o ? hold_run : hold_run + 1);
      prev_ras   = ras_n_o;
      prev_cas   = cas_n_o;
    end
  end

  initial begin
    #(200000 * 8);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int dones;
    bit quiet;
    repeat (3) @(negedge clk_i);
    chk(ras_n_o && cas_n_o, "R1 strobes idle in reset", {ras_n_o, cas_n_o}, 3);
    chk(!ref_req_o && !ref_done_o && !ref_urgent_o && !init_done_o,
        "R1 outputs low in reset",
        {ref_req_o, ref_done_o, ref_urgent_o, init_done_o}, 0);
    rst_ni = 1'b1;

    // R2/R3 pause and initial burst
    n = 0;
    quiet = 1'b1;
    do begin
      @(posedge clk_i);
      n++;
      @(negedge clk_i);
      if (n <= PAUSE && !(ras_n_o && cas_n_o)) quiet = 1'b0;
    end while (!init_done_o && n < 5000);
    chk(quiet, "R2 strobes quiet during pause", quiet, 1);
    chk(n == NINIT, "R2 init_done edge", n, NINIT);
    chk(cbr_cnt == BURST, "R3 init burst count", cbr_cnt, BURST);

    // R8/R9 first request and handshake
    e = 0;
    step_to(IV - 1);
    chk(!ref_req_o, "R8 no req before interval", ref_req_o, 0);
    step();
    chk(ref_req_o, "R8 req after interval", ref_req_o, 1);
    ref_gnt_i = 1'b1;
    step();
    ref_gnt_i = 1'b0;
    chk(!ref_req_o, "R9 req drops on grant", ref_req_o, 0);
    step_to(IV + TOT - 1);
    chk(!ref_done_o, "R9 done not early", ref_done_o, 0);
    step();
    chk(ref_done_o, "R9 done pulse", ref_done_o, 1);
    step();
    chk(!ref_done_o, "R9 done one cycle", ref_done_o, 0);
    chk(!ref_req_o, "R9 no req when nothing owed", ref_req_o, 0);

    // R10 tick and grant on the same edge
    step_to(3 * IV - 1);
    chk(ref_req_o, "R10 req pending", ref_req_o, 1);
    ref_gnt_i = 1'b1;
    step();
    ref_gnt_i = 1'b0;
    step_to(3 * IV + TOT - 1);
    chk(ref_done_o, "R10 first done", ref_done_o, 1);
    step();
    chk(ref_req_o, "R10 tick kept after same-edge grant", ref_req_o, 1);
    ref_gnt_i = 1'b1;
    step();
    ref_gnt_i = 1'b0;
    step_to(3 * IV + 2 * TOT + 1);
    chk(!ref_req_o, "R10 drained", ref_req_o, 0);

    // R12 urgency, R11 saturation
    step_to(6 * IV - 1);
    chk(!ref_urgent_o, "R12 urgent below level", ref_urgent_o, 0);
    chk(ref_req_o, "R8 req while owed", ref_req_o, 1);
    step();
    chk(ref_urgent_o, "R12 urgent at level", ref_urgent_o, 1);
    step_to(8 * IV + 4);
    ref_gnt_i = 1'b1;
    dones = 0;
    while (e < 9 * IV - 2) begin
      step();
      if (ref_done_o) dones++;
    end
    ref_gnt_i = 1'b0;
    chk(dones == MAXP, "R11 saturated drain count", dones, MAXP);
    chk(!ref_req_o, "R11 nothing left after drain", ref_req_o, 0);
    chk(!ref_urgent_o, "R12 urgent cleared", ref_urgent_o, 0);
    chk(cbr_cnt == BURST + 3 + MAXP, "R9 no unowed refresh", cbr_cnt, BURST + 3 + MAXP);
    chk(we_ok, "R7 write strobe inactive", we_ok, 1);
    chk(!req_early, "R3 no req before init_done", req_early, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule